// File: doc/BRIEF.md
# Machine State Register Move Unit

This unit carries out the three instructions that move data between the machine state register and a general register. Two of them write the state register from a source operand: a narrow form that changes only the lower-order half of the register, and a wide form that changes nearly all of it. The third returns the current state register as a general-register result. Each cycle the unit takes an operation code, the current 64-bit state register, the 64-bit source operand and the 1-bit L field. One clock edge later it presents either a new state register value or a general-register result, each with its own valid flag.

The L field picks the kind of write. With L set, the write is partial and touches only two bits. With L clear, the write is full. In a full write, the problem-state bit of the source forces the external-interrupt enable and both address-translation enables on. The wide form also applies a guarded rule to the three-bit transactional-state field.

All bit positions below use big-endian (MSB0) numbering: bit 0 is the most significant bit of the 64-bit word, so MSB0 bit k is vector index 63-k. Privilege checks, context synchronisation and writeback arbitration are handled elsewhere.

Top module: `msr_move_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `msr_vld_o` and `gpr_vld_o` are 0 and `msr_o` and `gpr_o` are all zeros.
- R2: The outputs are registered. The result for the inputs sampled at a rising clock edge appears just after that same edge and holds until the next edge.
- R3: For either write operation (`op_i` = 2'b01 narrow, 2'b10 wide) with `l_i` = 1, only MSB0 bits 48 and 62 of the new value are taken from `rs_i`. All other bits equal `msr_i`.
- R4: For either write operation with `l_i` = 0, new MSB0 bits 48, 58 and 59 each equal the same bit of `rs_i` ORed with `rs_i` MSB0 bit 49.
- R5: For the narrow write with `l_i` = 0, MSB0 bits 32–47, 49–50, 52–57 and 60–62 are copied from `rs_i`, and MSB0 bits 0–31 keep their `msr_i` value.
- R6: For the wide write with `l_i` = 0, MSB0 bits 0–2, 4–28, 32–47, 49–50, 52–57 and 60–62 are copied from `rs_i`.
- R7: For the wide write with `l_i` = 0, MSB0 bits 29–31 take `rs_i` bits 29–31. The one exception is when `msr_i` bits 29–31 are 3'b010 and `rs_i` bits 29–31 are 3'b000; then the old value is kept.
- R8: In any full write, MSB0 bits outside the ranges of R4, R5, R6 and R7 (bits 51 and 63, and bit 3 in the wide form) keep their `msr_i` value.
- R9: For the read operation (`op_i` = 2'b11), `gpr_o` equals `msr_i` and `gpr_vld_o` is 1 whatever `l_i` is, while `msr_vld_o` is 0 and `msr_o` is zero.
- R10: For either write operation, `msr_vld_o` is 1, `gpr_vld_o` is 0 and `gpr_o` is zero.
- R11: For the idle code (`op_i` = 2'b00), both valid flags are 0 and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 2 | Operation: 00 idle, 01 narrow write, 10 wide write, 11 read |
| l_i | input | 1 | L field: 1 partial write, 0 full write |
| msr_i | input | 64 | Current state register |
| rs_i | input | 64 | Source operand for writes |
| msr_o | output | 64 | New state register value |
| msr_vld_o | output | 1 | `msr_o` holds a write result |
| gpr_o | output | 64 | Read result |
| gpr_vld_o | output | 1 | `gpr_o` holds a read result |

## Verification
Two rules can act on the same wide full write. The problem-state bit forces three enables on, and the transactional field is held back when the guard condition is met. The sweep covers every combination of the problem-state bit, the old transactional field and the new transactional field. It repeats this under several pseudo-random background words for every operation code and both L values, so both rules meet in the same cycle many times. Each result is split into field groups and compared with a bitwise model of the requirements. A fault in one rule is therefore reported against that rule, even when the other rule acts in the same cycle.

// File: rtl/msr_move_pkg.sv
// Package: shared word type, operation codes and the MSB0 field masks
// of the state register. Assumes a 64-bit register with MSB0 numbering.
package msr_move_pkg;

    localparam int MSR_W = 64;
    localparam int OP_W  = 2;

    typedef logic [MSR_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        MV_IDLE = 2'd0,
        MV_TO32 = 2'd1,
        MV_TO64 = 2'd2,
        MV_FROM = 2'd3
    } mv_op_e;

    // Convert an MSB0 bit number to a vector index.
    function automatic int bidx(input int k);
        return MSR_W - 1 - k;
    endfunction

    // Build a mask covering MSB0 bits lo..hi inclusive.
    function automatic word_t span(input int lo, input int hi);
        word_t m;
        m = '0;
        for (int k = lo; k <= hi; k++) m[MSR_W-1-k] = 1'b1;
        return m;
    endfunction

    localparam int PR_POS = 49;
    localparam int TX_LO  = 29;
    localparam int TX_HI  = 31;
    localparam int TX_W   = TX_HI - TX_LO + 1;

    localparam logic [TX_W-1:0] TX_HOLD_OLD = 3'b010;
    localparam logic [TX_W-1:0] TX_HOLD_NEW = 3'b000;

    localparam word_t NARROW_COPY = span(32, 47) | span(49, 50) |
                                    span(52, 57) | span(60, 62);
    localparam word_t WIDE_COPY   = NARROW_COPY | span(0, 2) | span(4, 28);
    localparam word_t FORCE_SET   = span(48, 48) | span(58, 59);
    localparam word_t PARTIAL_SET = span(48, 48) | span(62, 62);
    localparam word_t TX_FIELD    = span(TX_LO, TX_HI);

endpackage

// File: rtl/msr_partial_upd.sv
// Partial write (L = 1): takes the two bits in PARTIAL_SET from the
// source operand and keeps every other bit of the old register.
// Purely combinational.
module msr_partial_upd
    import msr_move_pkg::*;
(
    input  word_t old_i,
    input  word_t src_i,
    output word_t nxt_o
);

    // Merge the partial-set bits from the source into the old value.
    always_comb begin
        nxt_o = (old_i & ~PARTIAL_SET) | (src_i & PARTIAL_SET);
    end

endmodule

// File: rtl/msr_tx_guard.sv
// Guarded update of the transactional-state field: the new field is
// the source field unless the old/new pair is the held combination.
// Purely combinational.
module msr_tx_guard
    import msr_move_pkg::*;
#(
    parameter int FIELD_W = TX_W
) (
    input  logic [FIELD_W-1:0] old_i,
    input  logic [FIELD_W-1:0] src_i,
    output logic [FIELD_W-1:0] nxt_o
);

    logic hold;

    // Detect the one pair of old/new values that leaves the field as it is.
    always_comb begin
        hold  = (old_i == FIELD_W'(TX_HOLD_OLD)) && (src_i == FIELD_W'(TX_HOLD_NEW));
        nxt_o = hold ? old_i : src_i;
    end

endmodule

// File: rtl/msr_full_upd.sv
// Full write (L = 0). WIDE_FORM selects the wide write (copy range
// includes the upper word, guarded transactional field) or the narrow
// write (upper word kept). In both forms the problem-state bit of the
// source forces the FORCE_SET bits on. Purely combinational.
module msr_full_upd
    import msr_move_pkg::*;
#(
    parameter bit WIDE_FORM = 1'b1
) (
    input  word_t old_i,
    input  word_t src_i,
    output word_t nxt_o
);

    localparam int PR_IDX = bidx(PR_POS);
    localparam int TX_MSB = bidx(TX_LO);
    localparam int TX_LSB = bidx(TX_HI);

    word_t copy_mask;
    word_t tx_mask;
    word_t tx_word;
    word_t forced;

    // Force bits: each is its source bit ORed with the problem-state bit.
    always_comb begin
        forced = (src_i | {MSR_W{src_i[PR_IDX]}}) & FORCE_SET;
    end

    generate
        if (WIDE_FORM) begin : g_wide
            logic [TX_W-1:0] tx_nxt;

            msr_tx_guard #(.FIELD_W(TX_W)) u_tx_guard (
                .old_i (old_i[TX_MSB:TX_LSB]),
                .src_i (src_i[TX_MSB:TX_LSB]),
                .nxt_o (tx_nxt)
            );

            // Place the guarded field into an otherwise empty word.
            always_comb begin
                tx_word                 = '0;
                tx_word[TX_MSB:TX_LSB]  = tx_nxt;
            end

            assign copy_mask = WIDE_COPY;
            assign tx_mask   = TX_FIELD;
        end else begin : g_narrow
            assign copy_mask = NARROW_COPY;
            assign tx_mask   = '0;
            assign tx_word   = '0;
        end
    endgenerate

    // Combine copied, forced, guarded and kept bits.
    always_comb begin
        nxt_o = (old_i & ~(copy_mask | FORCE_SET | tx_mask)) |
                (src_i & copy_mask) | forced | tx_word;
    end

endmodule

// File: rtl/msr_move_unit.sv
// Top: decodes the operation and the L field, picks one of the three
// update paths or the read path, and registers the result. Assumes
// synchronous active-low reset and one operation per cycle.
module msr_move_unit
    import msr_move_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic             l_i,
    input  logic [MSR_W-1:0] msr_i,
    input  logic [MSR_W-1:0] rs_i,
    output logic [MSR_W-1:0] msr_o,
    output logic             msr_vld_o,
    output logic [MSR_W-1:0] gpr_o,
    output logic             gpr_vld_o
);

    word_t part_nxt;
    word_t full32_nxt;
    word_t full64_nxt;
    word_t msr_d;
    word_t gpr_d;
    logic  msr_vld_d;
    logic  gpr_vld_d;

    msr_partial_upd u_partial (
        .old_i (msr_i),
        .src_i (rs_i),
        .nxt_o (part_nxt)
    );

    msr_full_upd #(.WIDE_FORM(1'b0)) u_full_narrow (
        .old_i (msr_i),
        .src_i (rs_i),
        .nxt_o (full32_nxt)
    );

    msr_full_upd #(.WIDE_FORM(1'b1)) u_full_wide (
        .old_i (msr_i),
        .src_i (rs_i),
        .nxt_o (full64_nxt)
    );

    // Select the result and valid flags for the current operation.
    always_comb begin
        msr_d     = '0;
        gpr_d     = '0;
        msr_vld_d = 1'b0;
        gpr_vld_d = 1'b0;
        case (mv_op_e'(op_i))
            MV_TO32: begin
                msr_d     = l_i ? part_nxt : full32_nxt;
                msr_vld_d = 1'b1;
            end
            MV_TO64: begin
                msr_d     = l_i ? part_nxt : full64_nxt;
                msr_vld_d = 1'b1;
            end
            MV_FROM: begin
                gpr_d     = msr_i;
                gpr_vld_d = 1'b1;
            end
            default: begin
                msr_d     = '0;
            end
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_o     <= '0;
            msr_vld_o <= 1'b0;
            gpr_o     <= '0;
            gpr_vld_o <= 1'b0;
        end else begin
            msr_o     <= msr_d;
            msr_vld_o <= msr_vld_d;
            gpr_o     <= gpr_d;
            gpr_vld_o <= gpr_vld_d;
        end
    end

endmodule

// File: rtl/msr_move_unit_chk.sv
// Checker for msr_move_unit: relates the registered outputs to the
// inputs sampled one edge earlier. Attached to the top by bind.
module msr_move_unit_chk
    import msr_move_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  op_i,
    input logic             l_i,
    input logic [MSR_W-1:0] msr_i,
    input logic [MSR_W-1:0] rs_i,
    input logic [MSR_W-1:0] msr_o,
    input logic             msr_vld_o,
    input logic [MSR_W-1:0] gpr_o,
    input logic             gpr_vld_o
);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msr_vld_o == (($past(op_i) == 2'd1) || ($past(op_i) == 2'd2)));

    p_partial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_vld_o && $past(l_i)) |->
        (((msr_o ^ $past(msr_i)) & ~PARTIAL_SET) == '0));

    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_vld_o && !$past(l_i) && $past(rs_i[14])) |->
        (msr_o[15] && msr_o[5] && msr_o[4]));

    p_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_vld_o && !$past(l_i) && ($past(op_i) == 2'd2) &&
         ($past(msr_i[34:32]) == 3'b010) && ($past(rs_i[34:32]) == 3'b000)) |->
        (msr_o[34:32] == 3'b010));

    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msr_vld_o |-> ((msr_o[12] == $past(msr_i[12])) && (msr_o[0] == $past(msr_i[0]))));

    p_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_vld_o |-> ((gpr_o == $past(msr_i)) && (msr_o == '0)));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msr_vld_o, gpr_vld_o}));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_vld_o && !gpr_vld_o) |-> ((msr_o == '0) && (gpr_o == '0)));

endmodule

bind msr_move_unit msr_move_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .l_i       (l_i),
    .msr_i     (msr_i),
    .rs_i      (rs_i),
    .msr_o     (msr_o),
    .msr_vld_o (msr_vld_o),
    .gpr_o     (gpr_o),
    .gpr_vld_o (gpr_vld_o)
);

// File: tb/msr_move_unit_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every operation code and L value against all
// combinations of the problem-state bit and both transactional fields,
// over several pseudo-random background words, and compares each
// output field group with a bitwise model.
module msr_move_unit_bench;

    logic        clk;
    logic        rst_n;
    logic [1:0]  op_i;
    logic        l_i;
    logic [63:0] msr_i;
    logic [63:0] rs_i;
    logic [63:0] msr_o;
    logic        msr_vld_o;
    logic [63:0] gpr_o;
    logic        gpr_vld_o;

    int n_chk;
    int n_fail;

    msr_move_unit u_msr_move_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .l_i       (l_i),
        .msr_i     (msr_i),
        .rs_i      (rs_i),
        .msr_o     (msr_o),
        .msr_vld_o (msr_vld_o),
        .gpr_o     (gpr_o),
        .gpr_vld_o (gpr_vld_o)
    );

    // 200 MHz clock
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic bit in_rng(input int k, input int lo, input int hi);
        return (k >= lo) && (k <= hi);
    endfunction

    function automatic logic [63:0] mask_of(input int lo, input int hi);
        logic [63:0] m;
        m = '0;
        for (int k = lo; k <= hi; k++) m[63-k] = 1'b1;
        return m;
    endfunction

    // Bitwise model of a write, straight from the requirements.
    function automatic logic [63:0] model(input bit wide, input bit l,
                                          input logic [63:0] m, input logic [63:0] s);
        logic [63:0] o;
        logic        pr;
        pr = s[63-49];
        o  = m;
        for (int k = 0; k < 64; k++) begin
            if (l) begin
                if (k == 48 || k == 62) o[63-k] = s[63-k];
            end else if (k == 48 || k == 58 || k == 59) begin
                o[63-k] = s[63-k] | pr;
            end else if (in_rng(k,32,47) || in_rng(k,49,50) ||
                         in_rng(k,52,57) || in_rng(k,60,62)) begin
                o[63-k] = s[63-k];
            end else if (wide && (in_rng(k,0,2) || in_rng(k,4,28))) begin
                o[63-k] = s[63-k];
            end
        end
        if (wide && !l && !((m[34:32] == 3'b010) && (s[34:32] == 3'b000)))
            o[34:32] = s[34:32];
        return o;
    endfunction

    function automatic logic [63:0] next_rand(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic check(input string req, input logic [63:0] got,
                         input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (op=%0d l=%0b msr=%h rs=%h)",
                     req, got, exp, op_i, l_i, msr_i, rs_i);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic l,
                         input logic [63:0] m, input logic [63:0] s);
        op_i  = op;
        l_i   = l;
        msr_i = m;
        rs_i  = s;
        @(posedge clk);
        #1;
    endtask

    // Compare one applied vector against the model by field group.
    task automatic judge(input logic [1:0] op, input logic l,
                         input logic [63:0] m, input logic [63:0] s);
        logic [63:0] exp;
        logic [63:0] frc;
        logic [63:0] cpy;
        logic [63:0] txm;
        logic [63:0] keep;
        bit          wide;
        wide = (op == 2'd2);
        frc  = mask_of(48,48) | mask_of(58,59);
        txm  = wide ? mask_of(29,31) : 64'd0;
        if (op == 2'd1 || op == 2'd2) begin
            exp = model(wide, l, m, s);
            check("R10 msr_vld", {63'd0, msr_vld_o}, 64'd1);
            check("R10 gpr_vld", {63'd0, gpr_vld_o}, 64'd0);
            check("R10 gpr zero", gpr_o, 64'd0);
            if (l) begin
                check("R3 partial", msr_o, exp);
            end else begin
                cpy = mask_of(32,47) | mask_of(49,50) | mask_of(52,57) | mask_of(60,62);
                if (wide) cpy = cpy | mask_of(0,2) | mask_of(4,28);
                else      cpy = cpy | mask_of(0,31);
                keep = ~(frc | cpy | txm);
                check("R4 forced", msr_o & frc, exp & frc);
                if (wide) begin
                    check("R6 wide copy", msr_o & cpy, exp & cpy);
                    check("R7 tx guard", msr_o & txm, exp & txm);
                end else begin
                    check("R5 narrow copy", msr_o & cpy, exp & cpy);
                end
                check("R8 kept", msr_o & keep, exp & keep);
            end
        end else if (op == 2'd3) begin
            check("R9 read data", gpr_o, m);
            check("R9 gpr_vld", {63'd0, gpr_vld_o}, 64'd1);
            check("R9 msr_vld", {63'd0, msr_vld_o}, 64'd0);
            check("R9 msr zero", msr_o, 64'd0);
        end else begin
            check("R11 valids", {62'd0, msr_vld_o, gpr_vld_o}, 64'd0);
            check("R11 msr zero", msr_o, 64'd0);
            check("R11 gpr zero", gpr_o, 64'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] seed;
        logic [63:0] m;
        logic [63:0] s;
        n_chk  = 0;
        n_fail = 0;
        rst_n  = 1'b0;
        op_i   = 2'd3;
        l_i    = 1'b0;
        msr_i  = 64'hFFFF_FFFF_FFFF_FFFF;
        rs_i   = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs held clear during reset even with a read pending
        check("R1 msr", msr_o, 64'd0);
        check("R1 gpr", gpr_o, 64'd0);
        check("R1 valids", {62'd0, msr_vld_o, gpr_vld_o}, 64'd0);
        op_i  = 2'd0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", {62'd0, msr_vld_o, gpr_vld_o}, 64'd0);

        // R2: result appears just after the sampling edge and then holds
        op_i  = 2'd3;
        msr_i = 64'h0123_4567_89AB_CDEF;
        check("R2 not before edge", {63'd0, gpr_vld_o}, 64'd0);
        @(posedge clk);
        #1;
        op_i = 2'd0;
        check("R2 after edge", gpr_o, 64'h0123_4567_89AB_CDEF);
        #2;
        check("R2 held", {63'd0, gpr_vld_o}, 64'd1);
        @(posedge clk);
        #1;
        check("R2 cleared", {63'd0, gpr_vld_o}, 64'd0);

        // Sweep: backgrounds x (pr, old tx, new tx) x op x L
        seed = 64'h9E37_79B9_7F4A_7C15;
        for (int bg = 0; bg < 4; bg++) begin
            for (int c = 0; c < 128; c++) begin
                seed = next_rand(seed);
                m    = (bg == 0) ? 64'd0 : (bg == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : seed;
                seed = next_rand(seed);
                s    = (bg == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : (bg == 1) ? 64'd0 : seed;
                m[34:32] = c[2:0];
                s[34:32] = c[5:3];
                s[14]    = c[6];
                for (int op = 0; op < 4; op++) begin
                    for (int l = 0; l < 2; l++) begin
                        apply(op[1:0], l[0], m, s);
                        judge(op[1:0], l[0], m, s);
                    end
                end
            end
        end

        // R7: the held pair in the wide form, directed
        apply(2'd2, 1'b0, 64'h0000_0002_0000_0000, 64'd0);
        check("R7 held pair", {61'd0, msr_o[34:32]}, 64'd2);
        // R7: same new value but old differs, so the field is replaced
        apply(2'd2, 1'b0, 64'h0000_0003_0000_0000, 64'd0);
        check("R7 replaced", {61'd0, msr_o[34:32]}, 64'd0);
        // R4: problem-state bit alone forces the three enables on
        apply(2'd1, 1'b0, 64'd0, 64'h0000_0000_0000_4000);
        check("R4 directed", msr_o & 64'h0000_0000_0000_8030, 64'h0000_0000_0000_8030);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule